// File: doc/BRIEF.md
# Banked Bit-Addressable Data Space

This block holds the 256-address internal data space of a small 8-bit processor core. Behind those addresses sit three separate 128-byte stores, 384 bytes in all. The lower RAM covers addresses 00h-7Fh. The upper RAM and the special-register file both cover 80h-FFh, and the kind of access decides which one answers. The core's decode logic drives three access ports into the block at the same time: a byte port for direct or indirect byte access, a register port for the eight working registers, and a bit port for single-bit reads and changes.

The working registers live in the lower RAM. A two-bit bank selection moves them between four groups of eight bytes. The bit port takes an 8-bit bit number. The lower half of that range selects bits in a 16-byte bit area of the lower RAM. The upper half selects bits in the special registers whose address is a multiple of eight. Every bit change is a read-modify-write of the target byte that finishes within one clock. All three ports read combinationally from the stored state, and all writes land on the rising clock edge.

Top module: `idata_space`

## Requirements
- R1: Byte addresses 00h-7Fh reach the same lower RAM byte whether `byte_ind_i` is 0 (direct) or 1 (indirect).
- R2: For byte addresses 80h-FFh, indirect access (`byte_ind_i`=1) reaches the upper RAM and direct access (`byte_ind_i`=0) reaches the special-register file. A write through one never changes what the other returns.
- R3: Register index n on the register port maps to lower RAM byte bank*8+n, where bank is the value of `bank_sel_i` captured at the previous rising edge.
- R4: Asynchronous reset clears all 384 bytes and the captured bank. The first register-port access after reset therefore maps to 00h-07h whatever `bank_sel_i` holds.
- R5: A bit number b below 80h addresses bit b[2:0] of lower RAM byte 20h + b[6:3]. For example, bit 78h is bit 0 of byte 2Fh.
- R6: A bit number b of 80h or above addresses bit b[2:0] of the special register at byte address b with its low three bits cleared (a multiple of eight).
- R7: The `bit_op_i` encoding is 0 read only, 1 set, 2 clear, 3 load `bit_wval_i`. A bit operation changes only the addressed bit, and op 0 changes nothing.
- R8: When ports write the same byte in one cycle, the register port overrides the byte port, and the bit port then overrides its own bit of the merged value.
- R9: Read outputs show the stored value before the edge, including in a cycle that writes the location. Writes are visible after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_addr_i | input | 8 | Byte port address |
| byte_ind_i | input | 1 | 1 selects indirect access, 0 selects direct |
| byte_we_i | input | 1 | Byte port write enable |
| byte_wdata_i | input | 8 | Byte port write data |
| byte_rdata_o | output | 8 | Byte port read data |
| reg_idx_i | input | 3 | Working register index |
| reg_we_i | input | 1 | Register port write enable |
| reg_wdata_i | input | 8 | Register port write data |
| reg_rdata_o | output | 8 | Register port read data |
| bit_addr_i | input | 8 | Bit number |
| bit_op_i | input | 2 | Bit operation: 0 read, 1 set, 2 clear, 3 load |
| bit_wval_i | input | 1 | Value for the load operation |
| bit_rdata_o | output | 1 | Current value of the addressed bit |
| bank_sel_i | input | 2 | Working register bank selection |

## Verification
The bench builds the block with its default sizes: an 8-bit address, 8-bit data and three 128-byte stores. At these sizes a few thousand random cycles cover all 256 bit numbers, all four banks and both access modes. Random addresses are biased toward the bit area and the bank region, so same-cycle collisions between the three write ports occur often. Directed cases cover the bank state after reset, the split of 80h-FFh between the two stores, the 78h example and the write priority.

// File: rtl/idata_pkg.sv
package idata_pkg;
  localparam int unsigned DW       = 8;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned IDX_W    = ADDR_W - 1;
  localparam int unsigned RG_DEPTH = 1 << IDX_W;
  localparam int unsigned REG_W    = 3;
  localparam int unsigned BANK_W   = 2;
  localparam int unsigned POS_W    = $clog2(DW);
  localparam int unsigned BIT_BASE = 32;  // 20h
  localparam int unsigned NRG      = 3;

  typedef enum logic [1:0] {
    RG_LOW = 2'd0,
    RG_UP  = 2'd1,
    RG_SFR = 2'd2
  } region_e;

  typedef enum logic [1:0] {
    BOP_READ = 2'd0,
    BOP_SET  = 2'd1,
    BOP_CLR  = 2'd2,
    BOP_PUT  = 2'd3
  } bit_op_e;
endpackage

// File: rtl/idata_store.sv
module idata_store #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned PW   = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_we_i,
  input  logic [IW-1:0] a_idx_i,
  input  logic [DW-1:0] a_wdata_i,
  input  logic          b_we_i,
  input  logic [IW-1:0] b_idx_i,
  input  logic [DW-1:0] b_wdata_i,
  input  logic          c_we_i,
  input  logic [IW-1:0] c_idx_i,
  input  logic [PW-1:0] c_pos_i,
  input  logic          c_val_i,
  output logic [DW-1:0] a_rdata_o,
  output logic [DW-1:0] b_rdata_o,
  output logic          c_rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];

  // later port overrides earlier: byte < register < bit
  always_comb begin
    for (int e = 0; e < int'(DEPTH); e++) begin
      mem_d[e] = mem_q[e];
      if (a_we_i && a_idx_i == IW'(e)) mem_d[e] = a_wdata_i;
      if (b_we_i && b_idx_i == IW'(e)) mem_d[e] = b_wdata_i;
      if (c_we_i && c_idx_i == IW'(e)) mem_d[e][c_pos_i] = c_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < int'(DEPTH); e++) mem_q[e] <= '0;
    end else begin
      for (int e = 0; e < int'(DEPTH); e++) mem_q[e] <= mem_d[e];
    end
  end

  assign a_rdata_o = mem_q[a_idx_i];
  assign b_rdata_o = mem_q[b_idx_i];
  assign c_rdata_o = mem_q[c_idx_i][c_pos_i];
endmodule

// File: rtl/idata_reg_map.sv
module idata_reg_map #(
  parameter int unsigned REG_W  = 3,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned IW     = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] bank_sel_i,
  input  logic [REG_W-1:0]  reg_idx_i,
  output logic [IW-1:0]     reg_ptr_o
);
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bank_q <= '0;
    else         bank_q <= bank_sel_i;
  end

  assign reg_ptr_o = IW'({bank_q, reg_idx_i});
endmodule

// File: rtl/idata_bit_map.sv
module idata_bit_map
  import idata_pkg::*;
#(
  parameter int unsigned AW   = 8,
  parameter int unsigned IW   = 7,
  parameter int unsigned PW   = 3,
  parameter int unsigned BASE = 32
) (
  input  logic [AW-1:0] bit_addr_i,
  output region_e       rg_o,
  output logic [IW-1:0] idx_o,
  output logic [PW-1:0] pos_o
);
  localparam int unsigned GW = AW - 1 - PW;
  logic [GW-1:0] grp;

  assign grp   = bit_addr_i[AW-2:PW];
  assign pos_o = bit_addr_i[PW-1:0];

  always_comb begin
    if (bit_addr_i[AW-1]) begin
      rg_o  = RG_SFR;
      idx_o = {grp, {PW{1'b0}}};
    end else begin
      rg_o  = RG_LOW;
      idx_o = IW'(BASE) + IW'(grp);
    end
  end
endmodule

// File: rtl/idata_space.sv
module idata_space
  import idata_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  byte_addr_i,
  input  logic               byte_ind_i,
  input  logic               byte_we_i,
  input  logic [DW-1:0]      byte_wdata_i,
  output logic [DW-1:0]      byte_rdata_o,
  input  logic [REG_W-1:0]   reg_idx_i,
  input  logic               reg_we_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  input  logic [ADDR_W-1:0]  bit_addr_i,
  input  logic [1:0]         bit_op_i,
  input  logic               bit_wval_i,
  output logic               bit_rdata_o,
  input  logic [BANK_W-1:0]  bank_sel_i
);
  region_e            byte_rg;
  region_e            bit_rg;
  logic [IDX_W-1:0]   reg_ptr;
  logic [IDX_W-1:0]   bit_idx;
  logic [POS_W-1:0]   bit_pos;
  logic               bit_wr;
  logic               bit_val;

  logic [DW-1:0] rd_byte [NRG];
  logic [DW-1:0] rd_reg  [NRG];
  logic          rd_bit  [NRG];

  // upper half: indirect reaches RAM, direct reaches special registers
  always_comb begin
    if (!byte_addr_i[ADDR_W-1]) byte_rg = RG_LOW;
    else if (byte_ind_i)        byte_rg = RG_UP;
    else                        byte_rg = RG_SFR;
  end

  always_comb begin
    bit_wr  = 1'b1;
    bit_val = 1'b0;
    unique case (bit_op_e'(bit_op_i))
      BOP_READ: bit_wr  = 1'b0;
      BOP_SET:  bit_val = 1'b1;
      BOP_CLR:  bit_val = 1'b0;
      BOP_PUT:  bit_val = bit_wval_i;
      default:  bit_wr  = 1'b0;
    endcase
  end

  idata_reg_map #(
    .REG_W (REG_W),
    .BANK_W(BANK_W),
    .IW    (IDX_W)
  ) u_reg_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bank_sel_i(bank_sel_i),
    .reg_idx_i (reg_idx_i),
    .reg_ptr_o (reg_ptr)
  );

  idata_bit_map #(
    .AW  (ADDR_W),
    .IW  (IDX_W),
    .PW  (POS_W),
    .BASE(BIT_BASE)
  ) u_bit_map (
    .bit_addr_i(bit_addr_i),
    .rg_o      (bit_rg),
    .idx_o     (bit_idx),
    .pos_o     (bit_pos)
  );

  for (genvar g = 0; g < int'(NRG); g++) begin : g_rg
    localparam region_e RG = region_e'(g);
    idata_store #(
      .DEPTH(RG_DEPTH),
      .DW   (DW)
    ) u_store (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .a_we_i   (byte_we_i && (byte_rg == RG)),
      .a_idx_i  (byte_addr_i[IDX_W-1:0]),
      .a_wdata_i(byte_wdata_i),
      .b_we_i   (reg_we_i && (RG == RG_LOW)),
      .b_idx_i  (reg_ptr),
      .b_wdata_i(reg_wdata_i),
      .c_we_i   (bit_wr && (bit_rg == RG)),
      .c_idx_i  (bit_idx),
      .c_pos_i  (bit_pos),
      .c_val_i  (bit_val),
      .a_rdata_o(rd_byte[g]),
      .b_rdata_o(rd_reg[g]),
      .c_rdata_o(rd_bit[g])
    );
  end

  assign byte_rdata_o = rd_byte[byte_rg];
  assign reg_rdata_o  = rd_reg[RG_LOW];
  assign bit_rdata_o  = rd_bit[bit_rg];
endmodule

// File: rtl/idata_space_chk.sv
module idata_space_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] byte_addr_i,
  input logic       byte_ind_i,
  input logic       byte_we_i,
  input logic [7:0] byte_wdata_i,
  input logic [7:0] byte_rdata_o,
  input logic [2:0] reg_idx_i,
  input logic       reg_we_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic [7:0] bit_addr_i,
  input logic [1:0] bit_op_i,
  input logic       bit_wval_i,
  input logic       bit_rdata_o,
  input logic [1:0] bank_sel_i
);
  p_bit_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_op_i == 2'd1) |=> (!$stable(bit_addr_i) || bit_rdata_o));

  p_bit_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_op_i == 2'd2) |=> (!$stable(bit_addr_i) || !bit_rdata_o));

  p_bit_put_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_op_i == 2'd3) |=> (!$stable(bit_addr_i) || bit_rdata_o == $past(bit_wval_i)));

  p_byte_visible_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_we_i && !reg_we_i && bit_op_i == 2'd0)
    |=> (!($stable(byte_addr_i) && $stable(byte_ind_i)) || byte_rdata_o == $past(byte_wdata_i)));

  // bit port beats byte port on a shared special register
  p_bit_over_byte_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_we_i && !byte_ind_i && bit_op_i != 2'd0 && bit_addr_i[7]
     && byte_addr_i == {bit_addr_i[7:3], 3'b000})
    |=> (!$stable(bit_addr_i) ||
         bit_rdata_o == ($past(bit_op_i == 2'd1) || ($past(bit_op_i == 2'd3) && $past(bit_wval_i)))));
endmodule

bind idata_space idata_space_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .byte_addr_i (byte_addr_i),
  .byte_ind_i  (byte_ind_i),
  .byte_we_i   (byte_we_i),
  .byte_wdata_i(byte_wdata_i),
  .byte_rdata_o(byte_rdata_o),
  .reg_idx_i   (reg_idx_i),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .bit_addr_i  (bit_addr_i),
  .bit_op_i    (bit_op_i),
  .bit_wval_i  (bit_wval_i),
  .bit_rdata_o (bit_rdata_o),
  .bank_sel_i  (bank_sel_i)
);

// File: tb/idata_space_bench.sv
module idata_space_bench;
  localparam int CLK_P = 10;
  localparam int N_RAND = 3000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] byte_addr_i = '0;
  logic       byte_ind_i = 1'b0;
  logic       byte_we_i = 1'b0;
  logic [7:0] byte_wdata_i = '0;
  logic [7:0] byte_rdata_o;
  logic [2:0] reg_idx_i = '0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [7:0] bit_addr_i = '0;
  logic [1:0] bit_op_i = '0;
  logic       bit_wval_i = 1'b0;
  logic       bit_rdata_o;
  logic [1:0] bank_sel_i = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  idata_space u_idata_space (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .byte_addr_i(byte_addr_i), .byte_ind_i(byte_ind_i), .byte_we_i(byte_we_i),
    .byte_wdata_i(byte_wdata_i), .byte_rdata_o(byte_rdata_o),
    .reg_idx_i(reg_idx_i), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .bit_addr_i(bit_addr_i), .bit_op_i(bit_op_i), .bit_wval_i(bit_wval_i),
    .bit_rdata_o(bit_rdata_o), .bank_sel_i(bank_sel_i)
  );

  // reference model
  logic [7:0] m_lo [128];
  logic [7:0] m_up [128];
  logic [7:0] m_sf [128];
  logic [1:0] m_bank;

  function automatic logic [7:0] exp_byte(logic [7:0] a, logic ind);
    if (!a[7]) return m_lo[a[6:0]];
    return ind ? m_up[a[6:0]] : m_sf[a[6:0]];
  endfunction

  function automatic logic [6:0] bit_byte(logic [7:0] b);
    if (b[7]) return {b[6:3], 3'b000};
    return 7'h20 + 7'(b[6:3]);
  endfunction

  function automatic logic exp_bit(logic [7:0] b);
    logic [7:0] v;
    v = b[7] ? m_sf[bit_byte(b)] : m_lo[bit_byte(b)];
    return v[b[2:0]];
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 128; i++) begin m_lo[i] = '0; m_up[i] = '0; m_sf[i] = '0; end
      m_bank = '0;
    end else begin
      logic nv;
      if (byte_we_i) begin
        if (!byte_addr_i[7])  m_lo[byte_addr_i[6:0]] = byte_wdata_i;
        else if (byte_ind_i)  m_up[byte_addr_i[6:0]] = byte_wdata_i;
        else                  m_sf[byte_addr_i[6:0]] = byte_wdata_i;
      end
      if (reg_we_i) m_lo[{2'b00, m_bank, reg_idx_i}] = reg_wdata_i;
      if (bit_op_i != 2'd0) begin
        nv = (bit_op_i == 2'd1) ? 1'b1 : (bit_op_i == 2'd2) ? 1'b0 : bit_wval_i;
        if (bit_addr_i[7]) m_sf[bit_byte(bit_addr_i)][bit_addr_i[2:0]] = nv;
        else               m_lo[bit_byte(bit_addr_i)][bit_addr_i[2:0]] = nv;
      end
      m_bank = bank_sel_i;
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(logic [7:0] ba, logic ind, logic bwe, logic [7:0] bwd,
                       logic [2:0] ri, logic rwe, logic [7:0] rwd,
                       logic [7:0] bta, logic [1:0] bop, logic bv, logic [1:0] bs);
    byte_addr_i = ba; byte_ind_i = ind; byte_we_i = bwe; byte_wdata_i = bwd;
    reg_idx_i = ri; reg_we_i = rwe; reg_wdata_i = rwd;
    bit_addr_i = bta; bit_op_i = bop; bit_wval_i = bv; bank_sel_i = bs;
  endtask

  // model checks on all three read ports, then one clock
  task automatic tick();
    #1;
    chk(byte_addr_i[7] ? "R2 byte" : "R1 byte", byte_rdata_o, exp_byte(byte_addr_i, byte_ind_i));
    chk("R3 reg", reg_rdata_o, m_lo[{2'b00, m_bank, reg_idx_i}]);
    chk(bit_addr_i[7] ? "R6 bit" : "R5 bit", {7'd0, bit_rdata_o}, {7'd0, exp_bit(bit_addr_i)});
    @(negedge clk_i);
  endtask

  task automatic peek(logic [7:0] a, logic ind, logic [7:0] exp, string req);
    apply(a, ind, 0, 0, 0, 0, 0, 0, 0, 0, bank_sel_i);
    #1;
    chk(req, byte_rdata_o, exp);
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5a_07c3));
    @(negedge clk_i);
    @(negedge clk_i);
    // R4: storage cleared during reset
    peek(8'h05, 0, 8'h00, "R4 reset lower");
    peek(8'h90, 1, 8'h00, "R4 reset upper");
    peek(8'hD0, 0, 8'h00, "R4 reset sfr");

    // R4: first register write after reset lands in bank 0
    rst_ni = 1'b1;
    apply(0, 0, 0, 0, 3'd2, 1, 8'hA5, 0, 0, 0, 2'd3);
    tick();
    peek(8'h02, 0, 8'hA5, "R4 bank0 after reset");
    peek(8'h1A, 0, 8'h00, "R4 bank3 untouched");
    // R3: bank 3 now captured
    apply(0, 0, 0, 0, 3'd7, 1, 8'h3C, 0, 0, 0, 2'd3);
    tick();
    peek(8'h1F, 0, 8'h3C, "R3 bank3 R7");

    // R1: direct write, indirect read
    apply(8'h45, 0, 1, 8'h77, 0, 0, 0, 0, 0, 0, 2'd3);
    tick();
    peek(8'h45, 1, 8'h77, "R1 alias");

    // R2: two stores behind 90h
    apply(8'h90, 0, 1, 8'h11, 0, 0, 0, 0, 0, 0, 2'd3);
    tick();
    apply(8'h90, 1, 1, 8'h22, 0, 0, 0, 0, 0, 0, 2'd3);
    tick();
    peek(8'h90, 0, 8'h11, "R2 direct sfr");
    peek(8'h90, 1, 8'h22, "R2 indirect upper");

    // R5: bit 78h is bit 0 of byte 2Fh; bit 0Fh is bit 7 of 21h
    apply(0, 0, 0, 0, 0, 0, 0, 8'h78, 2'd1, 0, 2'd3);
    tick();
    peek(8'h2F, 0, 8'h01, "R5 bit 78h");
    apply(0, 0, 0, 0, 0, 0, 0, 8'h0F, 2'd1, 0, 2'd3);
    tick();
    peek(8'h21, 0, 8'h80, "R5 bit 0Fh");

    // R6: bits D3h and D4h land in special register D0h
    apply(0, 0, 0, 0, 0, 0, 0, 8'hD3, 2'd1, 0, 2'd3);
    tick();
    apply(0, 0, 0, 0, 0, 0, 0, 8'hD4, 2'd1, 0, 2'd3);
    tick();
    peek(8'hD0, 0, 8'h18, "R6 sfr D0h");
    peek(8'hD0, 1, 8'h00, "R6 upper D0h untouched");

    // R7: clear, load, read-only op on byte 2Fh
    apply(8'h2F, 0, 1, 8'hA5, 0, 0, 0, 0, 0, 0, 2'd3);
    tick();
    apply(0, 0, 0, 0, 0, 0, 0, 8'h7D, 2'd2, 0, 2'd3);
    tick();
    peek(8'h2F, 0, 8'h85, "R7 clear bit5");
    apply(0, 0, 0, 0, 0, 0, 0, 8'h79, 2'd3, 1, 2'd3);
    tick();
    peek(8'h2F, 0, 8'h87, "R7 load bit1");
    apply(0, 0, 0, 0, 0, 0, 0, 8'h7F, 2'd0, 0, 2'd3);
    tick();
    peek(8'h2F, 0, 8'h87, "R7 read op no change");

    // R8: byte write and bit set together; register write beats byte write
    apply(8'h2F, 0, 1, 8'h00, 0, 0, 0, 8'h7F, 2'd1, 0, 2'd3);
    tick();
    peek(8'h2F, 0, 8'h80, "R8 bit over byte");
    apply(8'h18, 1, 1, 8'h55, 3'd0, 1, 8'hC3, 8'hC0, 2'd0, 0, 2'd3);
    tick();
    peek(8'h18, 0, 8'hC3, "R8 reg over byte");

    // R9: old value visible during the write cycle
    apply(8'h2E, 0, 0, 0, 0, 0, 0, 8'h70, 2'd1, 0, 2'd3);
    #1;
    chk("R9 bit pre-write", {7'd0, bit_rdata_o}, 8'h00);
    chk("R9 byte pre-write", byte_rdata_o, 8'h00);
    @(negedge clk_i);
    peek(8'h2E, 0, 8'h01, "R9 post-write");

    for (int n = 0; n < N_RAND; n++) begin
      logic [31:0] r;
      logic [7:0] ba;
      r = $urandom;
      ba = (r[1:0] == 2'd0) ? (8'h18 + 8'(r[5:2])) : 8'($urandom);
      apply(ba, r[6], r[9:7] < 3'd3, 8'($urandom),
            3'(r[12:10]), r[15:13] < 3'd2, 8'($urandom),
            r[16] ? 8'($urandom) : (8'h78 + 8'(r[19:17])), 2'(r[21:20]), r[22],
            r[26:24] == 3'd0 ? 2'(r[28:27]) : bank_sel_i);
      tick();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule